// File: doc/BRIEF.md
# Wrap-Bit Circular Queue Tracker

This block keeps the producer and consumer positions of a ring of entries held in memory. The ring holds a power-of-two number of slots, and a log2 size input sets that number. Each position is stored as a slot index with one extra wrap flag directly above the index bits. The block compares the two positions to report whether the ring is full or empty. From a base address and an entry size in bytes, it also gives the byte address of the slot that each side points at.

Either side can move its own position forward by one with a pulse, and software-style writes can load raw values. The consumer register also holds a 7-bit error code in its upper bits. A consumer step never touches that code. The queue size is taken from the input only while the queue is disabled. When a new size is taken, both positions return to zero, so the ring starts out empty.

Top module: `wrapq_tracker`

## Requirements
- R1: After reset both positions and the error code are zero, `empty_o` is 1, `full_o` is 0 and `size_o` is 0.
- R2: `empty_o` is 1 exactly when the producer and consumer agree on their low size+1 bits. Stored bits above bit `size_o` are ignored.
- R3: `full_o` is 1 exactly when the producer and consumer, masked to size+1 bits, differ only in bit `size_o` (the wrap flag). This holds at every size up to the maximum.
- R4: A producer step stores (producer+1) masked to size+1 bits. When the index runs past the last slot it returns to 0 and the wrap flag toggles.
- R5: A consumer step changes only the low size+1 bits of the consumer register, setting them to the low size+1 bits of (consumer+1). The error code in `cons_o[30:24]` and any stored pointer bits above bit `size_o` keep their values.
- R6: Each entry address is `base_i` with bits 5:0 cleared, plus `entry_size_i` times the low `size_o` bits of that position. The wrap flag does not affect the address.
- R7: A log2 size input above 19 is taken as 19.
- R8: When `en_i` is 0, `size_o` takes the clamped `log2size_i` at the next clock edge. If that value differs from the current size, both position fields clear to 0 at the same edge and the error code is kept. When `en_i` is 1, a change on `log2size_i` has no effect.
- R9: In a cycle where a raw write and a step arrive on the same side, the written value is stored.
- R10: `cons_o` places the consumer position in bits 19:0 and the error code in bits 30:24, with all other bits 0. `err_set_i` loads `err_code_i` into the error code. A consumer raw write loads `cons_werr_i` and takes priority over `err_set_i`.
- R11: `prod_o` holds the 20-bit producer position in bits 19:0 and 0 above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Queue enabled; while 1, the size is frozen |
| log2size_i | input | 5 | Requested log2 of the slot count |
| base_i | input | 52 | Ring base byte address |
| entry_size_i | input | 8 | Bytes per entry |
| prod_inc_i | input | 1 | Producer step pulse |
| prod_wr_i | input | 1 | Producer raw write strobe |
| prod_wdata_i | input | 20 | Producer raw write value |
| cons_inc_i | input | 1 | Consumer step pulse |
| cons_wr_i | input | 1 | Consumer raw write strobe |
| cons_wdata_i | input | 20 | Consumer position write value |
| cons_werr_i | input | 7 | Error code written with a consumer raw write |
| err_set_i | input | 1 | Load error code strobe |
| err_code_i | input | 7 | Error code to load |
| size_o | output | 5 | Log2 size in effect |
| prod_o | output | 32 | Producer register |
| cons_o | output | 32 | Consumer register with error code |
| full_o | output | 1 | Ring full |
| empty_o | output | 1 | Ring empty |
| prod_addr_o | output | 52 | Byte address of the producer slot |
| cons_addr_o | output | 52 | Byte address of the consumer slot |

## Verification
A wrong mask or a wrong stored position shows up at the ports in the cycle after the step or write that caused it. It appears first as a wrong `prod_o` or `cons_o`, and then as a full or empty flag with the wrong value or as a slot address shifted by a multiple of the entry size. Damage to the error code appears in `cons_o[30:24]` right after a consumer step. A size latch that follows the input while the queue is enabled shows up one cycle later as a changed `size_o` and as positions that were cleared. For these reasons, every scenario checks one edge after its stimulus.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic {
    PTR_MASK_ALL   = 1'b0,
    PTR_KEEP_UPPER = 1'b1
  } ptr_kind_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/wq_size_ctl.sv
module wq_size_ctl #(
  parameter int MAX_L2 = 19,
  parameter int L2_W   = 5,
  parameter int PTR_W  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [L2_W-1:0]  l2_i,
  output logic [L2_W-1:0]  l2_o,
  output logic             clr_o,
  output logic [PTR_W-1:0] wrap_mask_o,
  output logic [PTR_W-1:0] idx_mask_o,
  output logic [PTR_W-1:0] wi_mask_o
);
  localparam logic [L2_W-1:0] MaxL2V = L2_W'(MAX_L2);

  logic [L2_W-1:0] l2_q, l2_clamp;

  assign l2_clamp = (l2_i > MaxL2V) ? MaxL2V : l2_i;
  // new size only accepted while disabled; a change wipes the positions
  assign clr_o    = !en_i && (l2_clamp != l2_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    l2_q <= '0;
    else if (!en_i) l2_q <= l2_clamp;
  end

  assign l2_o        = l2_q;
  assign wrap_mask_o = PTR_W'(1) << l2_q;
  assign idx_mask_o  = wrap_mask_o - PTR_W'(1);
  assign wi_mask_o   = idx_mask_o | wrap_mask_o;
endmodule

// File: rtl/wq_ptr.sv
module wq_ptr
  import wq_pkg::*;
#(
  parameter int        PTR_W = 20,
  parameter ptr_kind_e KIND  = PTR_MASK_ALL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [PTR_W-1:0] wdata_i,
  input  logic             inc_i,
  input  logic [PTR_W-1:0] wi_mask_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, plus1, inc_val;

  assign plus1 = ptr_q + PTR_W'(1);

  generate
    if (KIND == PTR_KEEP_UPPER) begin : g_keep
      // only the wrap+index window moves; stored bits above it stay
      assign inc_val = (ptr_q & ~wi_mask_i) | (plus1 & wi_mask_i);
    end else begin : g_mask
      assign inc_val = plus1 & wi_mask_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (clr_i)  ptr_q <= '0;
    else if (wr_i)   ptr_q <= wdata_i;
    else if (inc_i)  ptr_q <= inc_val;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/wq_addr_gen.sv
module wq_addr_gen #(
  parameter int ADDR_W    = 52,
  parameter int ESZ_W     = 8,
  parameter int PTR_W     = 20,
  parameter int ALIGN_LSB = 6
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ESZ_W-1:0]  esize_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [PTR_W-1:0]  idx_mask_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PROD_W = ESZ_W + PTR_W;
  localparam logic [ADDR_W-1:0] BaseMask = ~((ADDR_W'(1) << ALIGN_LSB) - ADDR_W'(1));

  logic [PROD_W-1:0] offs;

  assign offs   = PROD_W'(esize_i) * PROD_W'(ptr_i & idx_mask_i);
  assign addr_o = (base_i & BaseMask) + ADDR_W'(offs);
endmodule

// File: rtl/wrapq_tracker.sv
module wrapq_tracker
  import wq_pkg::*;
#(
  parameter int MAX_L2  = 19,
  parameter int ADDR_W  = 52,
  parameter int ESZ_W   = 8,
  parameter int REG_W   = 32,
  parameter int ERR_LSB = 24,
  parameter int ERR_W   = 7,
  localparam int PTR_W  = MAX_L2 + 1,
  localparam int L2_W   = clog2_min1(MAX_L2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [L2_W-1:0]   log2size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ESZ_W-1:0]  entry_size_i,
  input  logic              prod_inc_i,
  input  logic              prod_wr_i,
  input  logic [PTR_W-1:0]  prod_wdata_i,
  input  logic              cons_inc_i,
  input  logic              cons_wr_i,
  input  logic [PTR_W-1:0]  cons_wdata_i,
  input  logic [ERR_W-1:0]  cons_werr_i,
  input  logic              err_set_i,
  input  logic [ERR_W-1:0]  err_code_i,
  output logic [L2_W-1:0]   size_o,
  output logic [REG_W-1:0]  prod_o,
  output logic [REG_W-1:0]  cons_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [ADDR_W-1:0] prod_addr_o,
  output logic [ADDR_W-1:0] cons_addr_o
);
  logic             clr;
  logic [PTR_W-1:0] wrap_m, idx_m, wi_m;
  logic [PTR_W-1:0] prod_p, cons_p, diff;
  logic [ERR_W-1:0] err_q;

  wq_size_ctl #(.MAX_L2(MAX_L2), .L2_W(L2_W), .PTR_W(PTR_W)) u_size (
    .clk_i, .rst_ni, .en_i,
    .l2_i(log2size_i), .l2_o(size_o), .clr_o(clr),
    .wrap_mask_o(wrap_m), .idx_mask_o(idx_m), .wi_mask_o(wi_m)
  );

  wq_ptr #(.PTR_W(PTR_W), .KIND(PTR_MASK_ALL)) u_prod (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(prod_wr_i), .wdata_i(prod_wdata_i),
    .inc_i(prod_inc_i), .wi_mask_i(wi_m), .ptr_o(prod_p)
  );

  wq_ptr #(.PTR_W(PTR_W), .KIND(PTR_KEEP_UPPER)) u_cons (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(cons_wr_i), .wdata_i(cons_wdata_i),
    .inc_i(cons_inc_i), .wi_mask_i(wi_m), .ptr_o(cons_p)
  );

  // error code sits beside the consumer position, untouched by steps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= '0;
    else if (cons_wr_i) err_q <= cons_werr_i;
    else if (err_set_i) err_q <= err_code_i;
  end

  assign diff    = (prod_p ^ cons_p) & wi_m;
  assign empty_o = (diff == '0);
  assign full_o  = (diff == wrap_m);

  always_comb begin
    prod_o = '0;
    prod_o[PTR_W-1:0] = prod_p;
    cons_o = '0;
    cons_o[PTR_W-1:0] = cons_p;
    cons_o[ERR_LSB +: ERR_W] = err_q;
  end

  wq_addr_gen #(.ADDR_W(ADDR_W), .ESZ_W(ESZ_W), .PTR_W(PTR_W)) u_paddr (
    .base_i, .esize_i(entry_size_i), .ptr_i(prod_p), .idx_mask_i(idx_m), .addr_o(prod_addr_o)
  );

  wq_addr_gen #(.ADDR_W(ADDR_W), .ESZ_W(ESZ_W), .PTR_W(PTR_W)) u_caddr (
    .base_i, .esize_i(entry_size_i), .ptr_i(cons_p), .idx_mask_i(idx_m), .addr_o(cons_addr_o)
  );
endmodule

// File: rtl/wrapq_tracker_chk.sv
module wrapq_tracker_chk #(
  parameter int MAX_L2  = 19,
  parameter int ADDR_W  = 52,
  parameter int ESZ_W   = 8,
  parameter int REG_W   = 32,
  parameter int ERR_LSB = 24,
  parameter int ERR_W   = 7,
  parameter int PTR_W   = 20,
  parameter int L2_W    = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [L2_W-1:0]   log2size_i,
  input logic              prod_inc_i,
  input logic              prod_wr_i,
  input logic [PTR_W-1:0]  prod_wdata_i,
  input logic              cons_inc_i,
  input logic              cons_wr_i,
  input logic              err_set_i,
  input logic [L2_W-1:0]   size_o,
  input logic [REG_W-1:0]  prod_o,
  input logic [REG_W-1:0]  cons_o,
  input logic              full_o,
  input logic              empty_o
);
  localparam logic [L2_W-1:0] MaxL2V = L2_W'(MAX_L2);

  logic [L2_W-1:0]  req_l2;
  logic             size_chg;
  logic [PTR_W-1:0] wi_now;

  assign req_l2   = (log2size_i > MaxL2V) ? MaxL2V : log2size_i;
  assign size_chg = !en_i && (req_l2 != size_o);
  assign wi_now   = (PTR_W'(2) << size_o) - PTR_W'(1);

  // R3
  full_empty_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({full_o, empty_o}));

  // R4
  prod_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_inc_i && !prod_wr_i && !size_chg) |=>
      prod_o[PTR_W-1:0] == (($past(prod_o[PTR_W-1:0]) + PTR_W'(1)) & wi_now));

  // R5
  cons_err_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_inc_i && !cons_wr_i && !err_set_i) |=>
      cons_o[ERR_LSB +: ERR_W] == $past(cons_o[ERR_LSB +: ERR_W]));

  // R7
  size_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_o <= MaxL2V);

  // R8
  size_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(size_o));

  // R8
  size_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_chg |=> (prod_o == '0) && (cons_o[PTR_W-1:0] == '0));

  // R9
  prod_wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_wr_i && !size_chg) |=> prod_o[PTR_W-1:0] == $past(prod_wdata_i));

  // R10
  cons_layout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cons_o[REG_W-1:ERR_LSB+ERR_W] == '0 && cons_o[ERR_LSB-1:PTR_W] == '0);
endmodule

bind wrapq_tracker wrapq_tracker_chk #(
  .MAX_L2(MAX_L2), .ADDR_W(ADDR_W), .ESZ_W(ESZ_W), .REG_W(REG_W),
  .ERR_LSB(ERR_LSB), .ERR_W(ERR_W), .PTR_W(PTR_W), .L2_W(L2_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .log2size_i(log2size_i),
  .prod_inc_i(prod_inc_i), .prod_wr_i(prod_wr_i), .prod_wdata_i(prod_wdata_i),
  .cons_inc_i(cons_inc_i), .cons_wr_i(cons_wr_i), .err_set_i(err_set_i),
  .size_o(size_o), .prod_o(prod_o), .cons_o(cons_o),
  .full_o(full_o), .empty_o(empty_o)
);

// File: tb/wrapq_tracker_bench.sv
module wrapq_tracker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [4:0]  l2 = '0;
  logic [51:0] base = '0;
  logic [7:0]  esz = '0;
  logic        p_inc = 1'b0, p_wr = 1'b0, c_inc = 1'b0, c_wr = 1'b0, e_set = 1'b0;
  logic [19:0] p_wd = '0, c_wd = '0;
  logic [6:0]  c_werr = '0, e_code = '0;
  logic [4:0]  size;
  logic [31:0] prod, cons;
  logic        full, empty;
  logic [51:0] p_addr, c_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrapq_tracker u_wrapq_tracker (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .log2size_i(l2), .base_i(base),
    .entry_size_i(esz), .prod_inc_i(p_inc), .prod_wr_i(p_wr), .prod_wdata_i(p_wd),
    .cons_inc_i(c_inc), .cons_wr_i(c_wr), .cons_wdata_i(c_wd), .cons_werr_i(c_werr),
    .err_set_i(e_set), .err_code_i(e_code), .size_o(size), .prod_o(prod),
    .cons_o(cons), .full_o(full), .empty_o(empty), .prod_addr_o(p_addr),
    .cons_addr_o(c_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [51:0] exp_addr(input logic [51:0] b, input logic [7:0] es,
                                           input logic [19:0] p, input int k);
    logic [51:0] idx;
    idx = 52'(p) & ((52'd1 << k) - 52'd1);
    return {b[51:6], 6'd0} + 52'(es) * idx;
  endfunction

  task automatic t_reset();
    chk("R1 prod", 64'(prod), 0);
    chk("R1 cons", 64'(cons), 0);
    chk("R1 empty", 64'(empty), 1);
    chk("R1 full", 64'(full), 0);
    chk("R1 size", 64'(size), 0);
  endtask

  task automatic t_setup();
    l2 = 5'd3;
    step();
    chk("R8 size taken while disabled", 64'(size), 3);
    en = 1'b1;
  endtask

  task automatic t_prod_wrap();
    p_inc = 1'b1;
    for (int i = 0; i < 7; i++) step();
    chk("R3 not full at 7", 64'(full), 0);
    step();
    chk("R4 prod wrap flag", 64'(prod), 32'h8);
    chk("R3 full", 64'(full), 1);
    chk("R2 not empty when full", 64'(empty), 0);
    for (int i = 0; i < 8; i++) step();
    p_inc = 1'b0;
    chk("R4 prod second wrap", 64'(prod), 0);
    chk("R2 empty after wrap", 64'(empty), 1);
  endtask

  task automatic t_mask();
    p_wr = 1'b1; p_wd = 20'h10;
    step();
    p_wr = 1'b0;
    chk("R11 prod raw", 64'(prod), 32'h10);
    chk("R2 upper bit ignored", 64'(empty), 1);
    p_inc = 1'b1;
    step();
    p_inc = 1'b0;
    chk("R4 step masks", 64'(prod), 32'h1);
    p_wr = 1'b1; p_wd = 20'h18;
    step();
    p_wr = 1'b0;
    chk("R3 full with upper bit", 64'(full), 1);
  endtask

  task automatic t_cons_err();
    c_wr = 1'b1; c_wd = 20'h40F; c_werr = '0;
    step();
    c_wr = 1'b0;
    e_set = 1'b1; e_code = 7'h55;
    step();
    e_set = 1'b0;
    chk("R10 err set", 64'(cons), 32'h5500040F);
    c_inc = 1'b1;
    step();
    chk("R5 cons step keeps err and upper", 64'(cons), 32'h55000400);
    step();
    c_inc = 1'b0;
    chk("R5 cons step again", 64'(cons), 32'h55000401);
  endtask

  task automatic t_priority();
    p_wr = 1'b1; p_wd = 20'h5; p_inc = 1'b1;
    c_wr = 1'b1; c_wd = 20'h2; c_werr = 7'h11; c_inc = 1'b1;
    e_set = 1'b1; e_code = 7'h7F;
    step();
    {p_wr, p_inc, c_wr, c_inc, e_set} = '0;
    chk("R9 prod write beats step", 64'(prod), 32'h5);
    chk("R9 R10 cons write beats step and err set", 64'(cons), 32'h11000002);
  endtask

  task automatic t_addr();
    base = 52'hABCD1234567F; esz = 8'd16;
    @(negedge clk);
    chk("R6 prod addr", 64'(p_addr), 64'(exp_addr(base, esz, 20'h5, 3)));
    chk("R6 cons addr", 64'(c_addr), 64'(exp_addr(base, esz, 20'h2, 3)));
    p_wr = 1'b1; p_wd = 20'hD;
    step();
    p_wr = 1'b0;
    chk("R6 wrap flag ignored", 64'(p_addr), 64'(exp_addr(base, esz, 20'h5, 3)));
  endtask

  task automatic t_size();
    l2 = 5'd5;
    step();
    chk("R8 size frozen while enabled", 64'(size), 3);
    chk("R8 prod kept while enabled", 64'(prod), 32'hD);
    en = 1'b0;
    step();
    en = 1'b1;
    chk("R8 new size", 64'(size), 5);
    chk("R8 prod cleared", 64'(prod), 0);
    chk("R8 cons cleared err kept", 64'(cons), 32'h11000000);
    p_wr = 1'b1; p_wd = 20'h21; c_wr = 1'b1; c_wd = 20'h01; c_werr = '0;
    step();
    {p_wr, c_wr} = '0;
    chk("R3 full at size 5", 64'(full), 1);
  endtask

  task automatic t_clamp();
    en = 1'b0; l2 = 5'd25;
    step();
    en = 1'b1;
    chk("R7 clamp", 64'(size), 19);
    p_wr = 1'b1; p_wd = 20'hFFFFF;
    step();
    p_wr = 1'b0; p_inc = 1'b1;
    step();
    p_inc = 1'b0;
    chk("R4 wrap at max size", 64'(prod), 0);
    chk("R2 empty at max size", 64'(empty), 1);
    p_wr = 1'b1; p_wd = 20'h80000;
    step();
    p_wr = 1'b0;
    chk("R3 full at max size", 64'(full), 1);
    chk("R6 addr at max size", 64'(p_addr), 64'(exp_addr(base, esz, 20'h80000, 19)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_prod_wrap();
    t_mask();
    t_cons_err();
    t_priority();
    t_addr();
    t_size();
    t_clamp();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule